// File: doc/BRIEF.md
# Smart Card Character Transceiver

This block moves single asynchronous characters across a half-duplex smart card data line. One transmit engine serialises a byte into a frame: a low start bit, eight data bits, one parity bit, and then a guard period with the line released. One receive engine watches the same line, detects a falling start edge, samples every bit near its centre, rebuilds the byte and flags a parity mismatch. The line output is open-drain. The block only pulls the line low and otherwise lets it float high, so the line input sees the wired-AND of this block and the card.

Three static control inputs choose the signalling convention. The first sets the bit order on the line. The second inverts the eight data bits, and only those. The third selects odd or even parity. Smart card characters carry even parity. With the inverse convention the data bits are inverted but the parity bit is not, so odd parity must be selected to get the correct line level. With all three controls clear, the initial character of a direct card decodes as 0x3B. With all three set, the initial character of an inverse card decodes as 0x3F. The bit period, called the elementary time unit (ETU), is a programmable number of clock cycles.

Top module: `sc_char_xcvr`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `tx_busy`, `line_drive_low`, `rx_valid` and `rx_par_err` are 0.
- R2: A `tx_start` seen at a clock edge while `tx_busy` is 0 is accepted. From the next cycle, the line carries ten bit slots of N = `etu_div` cycles each: start (low), eight data slots, then parity. `line_drive_low` is 1 exactly in the slots whose line level is low (0) and is 0 at all other times.
- R3: With `conv_msb_first` = 0, data slot i carries byte bit i (least significant bit first). With it at 1, slot i carries byte bit 7-i. The same order applies on receive.
- R4: With `conv_data_inv` = 1, each data slot's line level is the complement of its byte bit, on both transmit and receive. The parity slot is not inverted.
- R5: The transmitted parity level makes the number of high levels over the eight data slots plus the parity slot even when `conv_odd_par` = 0 and odd when it is 1. With all controls at 0, byte 0x3B sends a high parity slot. With all controls at 1, byte 0x3F also sends a high parity slot.
- R6: `tx_busy` rises in the cycle after acceptance and stays high for exactly 12N cycles: ten frame slots plus two guard slots with the line released. A `tx_start` while `tx_busy` is 1 is ignored.
- R7: Let E be the first clock edge that samples the start bit low on `line_in`. `rx_valid` is high for the single cycle after edge E + 3 + floor(N/2) + 9N. `rx_byte` then holds the byte decoded with the current order and inversion settings.
- R8: `rx_par_err` is high together with `rx_valid`, and only then. It is high when the count of high levels over the received eight data slots plus the parity slot disagrees with the selected odd/even rule.
- R9: A start bit that is back high at its mid-period sample is rejected. No `rx_valid` follows for it.
- R10: While `tx_busy` is high before a clock edge, no character is reported after that edge, so the block's own transmission is never received. A character whose last sample falls on the same edge that accepts a `tx_start` is still reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| etu_div | input | DIV_W | Clock cycles per bit period (N) |
| conv_msb_first | input | 1 | 1: most significant bit first on the line |
| conv_data_inv | input | 1 | 1: data bits inverted on the line |
| conv_odd_par | input | 1 | 1: odd parity, 0: even parity |
| tx_byte | input | 8 | Byte to send |
| tx_start | input | 1 | Send request, taken when not busy |
| tx_busy | output | 1 | Frame or guard time in progress |
| line_in | input | 1 | Sampled data line level |
| line_drive_low | output | 1 | 1: pull the data line low |
| rx_byte | output | 8 | Last received byte |
| rx_valid | output | 1 | One-cycle strobe for a received byte |
| rx_par_err | output | 1 | Parity mismatch, with `rx_valid` |

## Verification
The critical overlap is the receiver completing its parity sample on the same clock edge at which the transmitter accepts a new byte. The bench provokes it by computing, from the start edge of a character it drives onto the line, the edge on which the receiver will finish. It then raises `tx_start` so that the start request is taken on exactly that edge. The reference model expects both the receive strobe, with its byte and parity flag, and the full transmit frame that follows it. It also expects silence from the receiver for the rest of the block's own transmission.

// File: rtl/sc_char_pkg.sv
package sc_char_pkg;

    typedef struct packed {
        logic msb_first;
        logic data_inv;
        logic odd_par;
    } sc_conv_t;

    typedef enum logic [2:0] {
        TX_IDLE,
        TX_START,
        TX_DATA,
        TX_PAR,
        TX_GUARD
    } tx_state_e;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PAR
    } rx_state_e;

    // Byte to line levels in slot order (slot 0 goes first).
    function automatic logic [7:0] to_line(input logic [7:0] b, input sc_conv_t c);
        logic [7:0] lv;
        for (int i = 0; i < 8; i++) begin
            lv[i] = (c.msb_first ? b[7-i] : b[i]) ^ c.data_inv;
        end
        return lv;
    endfunction

    // Line levels in slot order back to a byte.
    function automatic logic [7:0] from_line(input logic [7:0] lv, input sc_conv_t c);
        logic [7:0] b;
        b = '0;
        for (int i = 0; i < 8; i++) begin
            if (c.msb_first) b[7-i] = lv[i] ^ c.data_inv;
            else             b[i]   = lv[i] ^ c.data_inv;
        end
        return b;
    endfunction

    // Parity slot level that completes the selected rule.
    function automatic logic parity_level(input logic [7:0] lv, input sc_conv_t c);
        return (^lv) ^ c.odd_par;
    endfunction

endpackage

// File: rtl/sc_line_sync.sv
module sc_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);

    generate
        if (STAGES <= 1) begin : g_single
            logic q;
            always_ff @(posedge clk) begin
                if (rst) q <= 1'b1;
                else     q <= din;
            end
            assign dout = q;
        end else begin : g_chain
            logic [STAGES-1:0] sr;
            always_ff @(posedge clk) begin
                if (rst) sr <= '1;
                else     sr <= {sr[STAGES-2:0], din};
            end
            assign dout = sr[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/sc_tx_engine.sv
module sc_tx_engine
    import sc_char_pkg::*;
#(
    parameter int DIV_W     = 16,
    parameter int GUARD_ETU = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] etu_div,
    input  sc_conv_t         conv,
    input  logic [7:0]       tx_byte,
    input  logic             tx_start,
    output logic             busy,
    output logic             line_low
);

    localparam int IDX_MAX = (GUARD_ETU > 8) ? GUARD_ETU : 8;
    localparam int IDX_W   = $clog2(IDX_MAX + 1);

    tx_state_e        state;
    logic [DIV_W-1:0] cnt;
    logic [IDX_W-1:0] idx;
    logic [7:0]       lv;
    logic             par;
    logic             slot_end;
    logic             level;

    assign slot_end = (cnt == etu_div - DIV_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= TX_IDLE;
            cnt   <= '0;
            idx   <= '0;
            lv    <= '0;
            par   <= 1'b1;
        end else if (state == TX_IDLE) begin
            if (tx_start) begin
                lv    <= to_line(tx_byte, conv);
                par   <= parity_level(to_line(tx_byte, conv), conv);
                state <= TX_START;
                cnt   <= '0;
                idx   <= '0;
            end
        end else if (!slot_end) begin
            cnt <= cnt + DIV_W'(1);
        end else begin
            cnt <= '0;
            case (state)
                TX_START: begin
                    state <= TX_DATA;
                    idx   <= '0;
                end
                TX_DATA: begin
                    if (idx == IDX_W'(7)) begin
                        state <= TX_PAR;
                        idx   <= '0;
                    end else begin
                        idx <= idx + IDX_W'(1);
                    end
                end
                TX_PAR: begin
                    state <= TX_GUARD;
                    idx   <= '0;
                end
                default: begin
                    if (idx == IDX_W'(GUARD_ETU - 1)) begin
                        state <= TX_IDLE;
                        idx   <= '0;
                    end else begin
                        idx <= idx + IDX_W'(1);
                    end
                end
            endcase
        end
    end

    always_comb begin
        case (state)
            TX_START: level = 1'b0;
            TX_DATA:  level = lv[idx[2:0]];
            TX_PAR:   level = par;
            default:  level = 1'b1;
        endcase
    end

    assign line_low = ~level;
    assign busy     = (state != TX_IDLE);

endmodule

// File: rtl/sc_rx_engine.sv
module sc_rx_engine
    import sc_char_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] etu_div,
    input  sc_conv_t         conv,
    input  logic             line_s,
    input  logic             hold,
    output logic [7:0]       rx_byte,
    output logic             rx_valid,
    output logic             rx_err
);

    rx_state_e        state;
    logic [DIV_W-1:0] cnt;
    logic [2:0]       idx;
    logic [7:0]       shreg;
    logic             prev;
    logic             slot_end;
    logic             mid_start;

    assign slot_end  = (cnt == etu_div - DIV_W'(1));
    assign mid_start = (cnt == (etu_div >> 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= RX_IDLE;
            cnt      <= '0;
            idx      <= '0;
            shreg    <= '0;
            prev     <= 1'b1;
            rx_byte  <= '0;
            rx_valid <= 1'b0;
            rx_err   <= 1'b0;
        end else begin
            prev     <= line_s;
            rx_valid <= 1'b0;
            rx_err   <= 1'b0;
            if (hold) begin
                state <= RX_IDLE;
                cnt   <= '0;
            end else begin
                case (state)
                    RX_IDLE: begin
                        if (prev && !line_s) begin
                            state <= RX_START;
                            cnt   <= '0;
                        end
                    end
                    RX_START: begin
                        if (mid_start) begin
                            cnt <= '0;
                            idx <= '0;
                            state <= line_s ? RX_IDLE : RX_DATA;
                        end else begin
                            cnt <= cnt + DIV_W'(1);
                        end
                    end
                    RX_DATA: begin
                        if (slot_end) begin
                            shreg[idx] <= line_s;
                            cnt        <= '0;
                            if (idx == 3'd7) state <= RX_PAR;
                            else             idx   <= idx + 3'd1;
                        end else begin
                            cnt <= cnt + DIV_W'(1);
                        end
                    end
                    default: begin
                        if (slot_end) begin
                            state    <= RX_IDLE;
                            cnt      <= '0;
                            rx_valid <= 1'b1;
                            rx_byte  <= from_line(shreg, conv);
                            rx_err   <= ((^shreg) ^ line_s) != conv.odd_par;
                        end else begin
                            cnt <= cnt + DIV_W'(1);
                        end
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/sc_char_xcvr.sv
module sc_char_xcvr
    import sc_char_pkg::*;
#(
    parameter int DIV_W       = 16,
    parameter int GUARD_ETU   = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] etu_div,
    input  logic             conv_msb_first,
    input  logic             conv_data_inv,
    input  logic             conv_odd_par,
    input  logic [7:0]       tx_byte,
    input  logic             tx_start,
    output logic             tx_busy,
    input  logic             line_in,
    output logic             line_drive_low,
    output logic [7:0]       rx_byte,
    output logic             rx_valid,
    output logic             rx_par_err
);

    sc_conv_t conv;
    logic     line_s;

    assign conv = '{msb_first: conv_msb_first, data_inv: conv_data_inv, odd_par: conv_odd_par};

    sc_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (line_in),
        .dout (line_s)
    );

    sc_tx_engine #(.DIV_W(DIV_W), .GUARD_ETU(GUARD_ETU)) u_tx (
        .clk      (clk),
        .rst      (rst),
        .etu_div  (etu_div),
        .conv     (conv),
        .tx_byte  (tx_byte),
        .tx_start (tx_start),
        .busy     (tx_busy),
        .line_low (line_drive_low)
    );

    sc_rx_engine #(.DIV_W(DIV_W)) u_rx (
        .clk      (clk),
        .rst      (rst),
        .etu_div  (etu_div),
        .conv     (conv),
        .line_s   (line_s),
        .hold     (tx_busy),
        .rx_byte  (rx_byte),
        .rx_valid (rx_valid),
        .rx_err   (rx_par_err)
    );

endmodule

// File: rtl/sc_char_xcvr_chk.sv
module sc_char_xcvr_chk (
    input logic clk,
    input logic rst,
    input logic tx_start,
    input logic tx_busy,
    input logic line_drive_low,
    input logic rx_valid,
    input logic rx_par_err
);

    p_drive_in_frame_r2: assert property (@(posedge clk) disable iff (rst)
        line_drive_low |-> tx_busy);

    p_start_bit_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_busy) |-> line_drive_low);

    p_accept_r6: assert property (@(posedge clk) disable iff (rst)
        (tx_start && !tx_busy) |=> tx_busy);

    p_err_with_valid_r8: assert property (@(posedge clk) disable iff (rst)
        rx_par_err |-> rx_valid);

    p_single_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);

    p_quiet_while_tx_r10: assert property (@(posedge clk) disable iff (rst)
        rx_valid |-> !$past(tx_busy));

endmodule

bind sc_char_xcvr sc_char_xcvr_chk u_chk (
    .clk            (clk),
    .rst            (rst),
    .tx_start       (tx_start),
    .tx_busy        (tx_busy),
    .line_drive_low (line_drive_low),
    .rx_valid       (rx_valid),
    .rx_par_err     (rx_par_err)
);

// File: tb/tb_sc_char_xcvr.sv
module tb_sc_char_xcvr;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] etu_div = 16'd8;
    logic        conv_msb_first = 1'b0;
    logic        conv_data_inv = 1'b0;
    logic        conv_odd_par = 1'b0;
    logic [7:0]  tx_byte = 8'h00;
    logic        tx_start = 1'b0;
    logic        tx_busy;
    logic        line_in;
    logic        line_drive_low;
    logic [7:0]  rx_byte;
    logic        rx_valid;
    logic        rx_par_err;
    logic        bench_low = 1'b0;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int valid_seen = 0;
    bit done = 0;
    string cur_req = "R2";

    assign line_in = ~(line_drive_low | bench_low);

    always #5 clk = ~clk;

    sc_char_xcvr dut (
        .clk            (clk),
        .rst            (rst),
        .etu_div        (etu_div),
        .conv_msb_first (conv_msb_first),
        .conv_data_inv  (conv_data_inv),
        .conv_odd_par   (conv_odd_par),
        .tx_byte        (tx_byte),
        .tx_start       (tx_start),
        .tx_busy        (tx_busy),
        .line_in        (line_in),
        .line_drive_low (line_drive_low),
        .rx_byte        (rx_byte),
        .rx_valid       (rx_valid),
        .rx_par_err     (rx_par_err)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Frame line levels: [0] start, [1..8] data slots, [9] parity.
    function automatic logic [9:0] mk_levels(input logic [7:0] b, input bit msb,
                                             input bit inv, input bit odd, input bit bad);
        logic [9:0] f;
        int ones;
        ones = 0;
        f[0] = 1'b0;
        for (int i = 0; i < 8; i++) begin
            f[1+i] = (msb ? b[7-i] : b[i]) ^ inv;
            if (f[1+i]) ones++;
        end
        f[9] = ((ones % 2) == 1) ^ odd ^ bad;
        return f;
    endfunction

    // Transmit reference model.
    bit         m_busy = 0;
    int         m_cnt = 0;
    logic [9:0] m_lv = '1;

    typedef struct { int at; logic [7:0] b; logic e; } rx_exp_t;
    rx_exp_t rq[$];

    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            m_busy = 0;
        end else if (m_busy) begin
            if (m_cnt == 12 * int'(etu_div) - 1) m_busy = 0;
            else m_cnt++;
        end else if (tx_start) begin
            m_busy = 1;
            m_cnt = 0;
            m_lv = mk_levels(tx_byte, conv_msb_first, conv_data_inv, conv_odd_par, 0);
        end
    end

    always @(negedge clk) begin
        if (cyc >= 1 && !done) begin
            bit exp_low;
            bit exp_v;
            exp_low = m_busy && (m_cnt < 10 * int'(etu_div)) && !m_lv[m_cnt / int'(etu_div)];
            chk(tx_busy == m_busy, cur_req, "tx_busy", tx_busy, m_busy);
            chk(line_drive_low == exp_low, cur_req, "line_drive_low", line_drive_low, exp_low);
            exp_v = (rq.size() > 0) && (rq[0].at == cyc);
            chk(rx_valid == exp_v, cur_req, "rx_valid", rx_valid, exp_v);
            if (!rx_valid) chk(!rx_par_err, "R8", "rx_par_err without valid", rx_par_err, 0);
            if (rx_valid) valid_seen++;
            if (exp_v) begin
                chk(rx_byte == rq[0].b, cur_req, "rx_byte", rx_byte, rq[0].b);
                chk(rx_par_err == rq[0].e, cur_req, "rx_par_err", rx_par_err, rq[0].e);
                void'(rq.pop_front());
            end
        end
    end

    task automatic send_tx(input logic [7:0] b);
        @(negedge clk);
        tx_byte = b;
        tx_start = 1'b1;
        @(negedge clk);
        tx_start = 1'b0;
        repeat (12 * int'(etu_div) + 2) @(negedge clk);
    endtask

    // Drives a frame from a negedge; returns the expected strobe cycle.
    task automatic drive_frame(input logic [9:0] f, output int at);
        int n;
        logic [7:0] b;
        int ones;
        rx_exp_t x;
        n = int'(etu_div);
        at = cyc + 1 + 3 + n / 2 + 9 * n;
        ones = 0;
        b = '0;
        for (int i = 0; i < 8; i++) begin
            if (conv_msb_first) b[7-i] = f[1+i] ^ conv_data_inv;
            else                b[i]   = f[1+i] ^ conv_data_inv;
            if (f[1+i]) ones++;
        end
        if (f[9]) ones++;
        x.at = at;
        x.b = b;
        x.e = ((ones % 2) == 1) != conv_odd_par;
        rq.push_back(x);
        for (int s = 0; s < 10; s++) begin
            bench_low = ~f[s];
            repeat (n) @(negedge clk);
        end
        bench_low = 1'b0;
    endtask

    task automatic set_conv(input bit msb, input bit inv, input bit odd);
        @(negedge clk);
        conv_msb_first = msb;
        conv_data_inv = inv;
        conv_odd_par = odd;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int at;
        int vs;
        cur_req = "R1";
        repeat (3) @(negedge clk);
        chk(tx_busy == 0, "R1", "reset tx_busy", tx_busy, 0);
        chk(line_drive_low == 0, "R1", "reset line_drive_low", line_drive_low, 0);
        chk(rx_valid == 0 && rx_par_err == 0, "R1", "reset rx strobes", rx_valid, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(tx_busy == 0 && rx_valid == 0, "R1", "after reset", tx_busy, 0);

        // Direct convention, 0x3B: parity slot must be released (high).
        cur_req = "R3";
        set_conv(0, 0, 0);
        @(negedge clk);
        tx_byte = 8'h3B;
        tx_start = 1'b1;
        @(negedge clk);
        tx_start = 1'b0;
        repeat (9 * 8 + 3) @(negedge clk);
        chk(line_drive_low == 0 && tx_busy == 1, "R5", "0x3B parity slot high", line_drive_low, 0);
        repeat (3 * 8 + 2) @(negedge clk);

        // Inverse convention, 0x3F: parity slot also high.
        cur_req = "R4";
        set_conv(1, 1, 1);
        @(negedge clk);
        tx_byte = 8'h3F;
        tx_start = 1'b1;
        @(negedge clk);
        tx_start = 1'b0;
        repeat (9 * 8 + 3) @(negedge clk);
        chk(line_drive_low == 0 && tx_busy == 1, "R5", "0x3F parity slot high", line_drive_low, 0);
        repeat (3 * 8 + 2) @(negedge clk);

        cur_req = "R3";
        set_conv(1, 0, 0);
        send_tx(8'hA5);
        cur_req = "R4";
        set_conv(0, 1, 1);
        send_tx(8'h01);
        cur_req = "R5";
        set_conv(0, 0, 1);
        send_tx(8'hC3);

        // Second request while busy is ignored.
        cur_req = "R6";
        set_conv(0, 0, 0);
        @(negedge clk);
        tx_byte = 8'h5A;
        tx_start = 1'b1;
        @(negedge clk);
        tx_start = 1'b0;
        repeat (20) @(negedge clk);
        tx_byte = 8'hFF;
        tx_start = 1'b1;
        @(negedge clk);
        tx_start = 1'b0;
        repeat (12 * 8) @(negedge clk);
        chk(tx_busy == 0, "R6", "idle after one frame", tx_busy, 0);

        // Receive paths.
        cur_req = "R7";
        set_conv(0, 0, 0);
        drive_frame(mk_levels(8'h3B, 0, 0, 0, 0), at);
        repeat (8) @(negedge clk);
        set_conv(1, 1, 1);
        drive_frame(mk_levels(8'h3F, 1, 1, 1, 0), at);
        repeat (8) @(negedge clk);
        chk(rx_byte == 8'h3F, "R4", "inverse 0x3F decoded", rx_byte, 8'h3F);
        cur_req = "R3";
        set_conv(1, 0, 0);
        drive_frame(mk_levels(8'h96, 1, 0, 0, 0), at);
        repeat (8) @(negedge clk);
        cur_req = "R8";
        set_conv(0, 0, 0);
        drive_frame(mk_levels(8'h71, 0, 0, 0, 1), at);
        repeat (8) @(negedge clk);
        set_conv(0, 1, 1);
        drive_frame(mk_levels(8'h0E, 0, 1, 1, 1), at);
        repeat (8) @(negedge clk);
        cur_req = "R7";
        set_conv(0, 0, 0);
        etu_div = 16'd11;
        drive_frame(mk_levels(8'hE4, 0, 0, 0, 0), at);
        repeat (11) @(negedge clk);
        etu_div = 16'd8;
        repeat (4) @(negedge clk);

        // False start.
        cur_req = "R9";
        vs = valid_seen;
        bench_low = 1'b1;
        repeat (2) @(negedge clk);
        bench_low = 1'b0;
        repeat (12 * 8) @(negedge clk);
        chk(valid_seen == vs, "R9", "glitch produced no byte", valid_seen - vs, 0);

        // Own transmission is not received.
        cur_req = "R10";
        vs = valid_seen;
        send_tx(8'h00);
        chk(valid_seen == vs, "R10", "own frame not reported", valid_seen - vs, 0);

        // Receive completion on the same edge as a transmit acceptance.
        at = cyc + 1 + 3 + 4 + 72;
        fork
            begin
                int a2;
                drive_frame(mk_levels(8'h6C, 0, 0, 0, 0), a2);
            end
            begin
                while (cyc != at - 1) @(negedge clk);
                tx_byte = 8'h99;
                tx_start = 1'b1;
                @(negedge clk);
                tx_start = 1'b0;
                chk(rx_valid == 1 && tx_busy == 1, "R10", "coincident strobe and busy",
                    {rx_valid, tx_busy}, 2'b11);
            end
        join
        repeat (12 * 8 + 4) @(negedge clk);
        chk(rq.size() == 0, "R7", "all expected bytes seen", rq.size(), 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule